// File: doc/BRIEF.md
# Multi-Carrier Quadrant-Phase Carrier Synthesizer

This block builds a digital transmit sample stream that is the sum of up to four cosine carriers. Each carrier has its own enable and an 8-bit frequency code k. The code selects a tone on a 0.1 MHz grid that starts at 5 MHz, so fc = 5 MHz + k x 0.1 MHz. Each carrier runs a phase accumulator at a fixed sample clock. A shared 2-bit quadrant code, driven by an upstream modulator, offsets the phase of every enabled carrier by the same multiple of 90 degrees. The block then looks each phase up in a quarter-wave table and adds the results into a signed word wide enough for an external DAC.

The redundant carriers carry identical modulation, and a receiver may use any one of them. The sample clock enable lets the block share a faster system clock. While it is low, no state moves. The tuning word for each code is computed from the sample rate that is fixed at build time. It is not stored as a table.

Top module: `quad_carrier_synth`

## Requirements
- R1: While reset is high, the sample output and every phase accumulator are cleared to zero, so the sample reads 0 on the first cycle after reset.
- R2: A carrier with code k advances its 32-bit accumulator by round((5e6 + k x 1e5) x 2^32 / FS_HZ) on each enabled tick, within one LSB. This keeps its frequency inside +/-0.02 % of the nominal value.
- R3: A code above 250 gives the same behaviour as code 250, which is the 30 MHz top of the band.
- R4: Each enabled carrier contributes round(A x cos(2 pi (p + 0.5) / 1024)) within one LSB, where A = 2^(CAR_W-1) - 1 and p is the top 10 bits of the accumulator plus the quadrant code shifted to bits 31:30.
- R5: Quadrant code q (0 = 0, 1 = 90, 2 = 180, 3 = 270 degrees) is added to the phase of every enabled carrier. A change of q affects only the samples that follow it and leaves the accumulators untouched.
- R6: A disabled carrier contributes zero and its accumulator is held at zero, so re-enabling it restarts at phase 0. After two ticks with all carriers disabled, the output is 0.
- R7: The sum carries clog2(NUM_CAR) guard bits. Four carriers in phase give exactly +4A or -4A with no wrap, and the output never leaves the range +/-NUM_CAR x A.
- R8: On a cycle with the sample enable low, the output and all internal state hold.
- R9: The output lags by two ticks. The accumulator value and quadrant code present at tick n show up in the output after tick n+1. A carrier enabled just before tick 1 gives 0 after tick 1 and +A after tick 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Sample-rate tick enable |
| car_en | input | NUM_CAR | Per-carrier enable |
| car_code | input | NUM_CAR x 8 | Frequency codes, carrier i in bits [8i+7:8i] |
| quad | input | 2 | Shared quadrant phase code |
| sample_o | output | OUT_W | Signed summed sample |

## Verification
The bench builds the block with its default values: four carriers, a 32-bit accumulator, 12-bit carrier samples and a 125 MHz sample rate. Four carriers are enough to reach the full-scale sum of +/-8188 that tests the guard bits. At 125 MHz the whole 5 to 30 MHz band lies below Nyquist, so codes 0, 125, 250 and the saturated code 255 all run against an ideal real-number model over more than a thousand samples. Over that many samples, a wrong tuning word drifts far enough to move the table bin.

// File: rtl/quad_carrier_synth_pkg.sv
package quad_carrier_synth_pkg;

    // Fixed frequency grid of the band
    localparam longint unsigned FC_BASE_HZ  = 64'd5_000_000;
    localparam longint unsigned FC_STEP_HZ  = 64'd100_000;
    localparam int              CODE_W      = 8;
    localparam int unsigned     FC_CODE_MAX = 250;

    // Quarter-wave table geometry
    localparam int LUT_AW    = 8;
    localparam int PHASE_TOP = LUT_AW + 2;

    typedef enum logic [1:0] {
        QUAD_0   = 2'd0,
        QUAD_90  = 2'd1,
        QUAD_180 = 2'd2,
        QUAD_270 = 2'd3
    } quad_e;

    typedef struct packed {
        logic [1:0]        quadrant;
        logic [LUT_AW-1:0] index;
    } lut_addr_t;

    // Phase increment scaled by 2^(acc_w + frac_w), floor.
    // Done as integer part plus remainder so nothing exceeds 64 bits.
    function automatic longint unsigned scaled_inc(
        input longint unsigned f_hz,
        input longint unsigned fs_hz,
        input int              acc_w,
        input int              frac_w
    );
        longint unsigned x;
        longint unsigned ip;
        longint unsigned rem;
        longint unsigned fp;
        x   = f_hz << acc_w;
        ip  = x / fs_hz;
        rem = x % fs_hz;
        fp  = (rem << frac_w) / fs_hz;
        return (ip << frac_w) | fp;
    endfunction

    function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] code);
        if (code > CODE_W'(FC_CODE_MAX))
            return CODE_W'(FC_CODE_MAX);
        return code;
    endfunction

endpackage

// File: rtl/quad_carrier_nco.sv
module quad_carrier_nco
    import quad_carrier_synth_pkg::*;
#(
    parameter int              ACC_W  = 32,
    parameter int              FRAC_W = 16,
    parameter longint unsigned FS_HZ  = 64'd125_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  quad_e             quad,
    output lut_addr_t         addr_o
);

    localparam int TWX_W = ACC_W + FRAC_W;
    localparam longint unsigned BASE_X = scaled_inc(FC_BASE_HZ, FS_HZ, ACC_W, FRAC_W);
    localparam longint unsigned STEP_X = scaled_inc(FC_STEP_HZ, FS_HZ, ACC_W, FRAC_W);
    localparam logic [TWX_W-1:0] HALF_X = TWX_W'(1) << (FRAC_W - 1);

    logic [CODE_W-1:0] code_c;
    logic [TWX_W-1:0]  tw_x;
    logic [ACC_W-1:0]  tw;
    logic [ACC_W-1:0]  acc;
    logic [PHASE_TOP-1:0] phase;

    // Tuning word: base + k * step in extended precision, then rounded
    always_comb begin
        code_c = clamp_code(code);
        tw_x   = BASE_X[TWX_W-1:0]
               + TWX_W'(code_c) * STEP_X[TWX_W-1:0]
               + HALF_X;
        tw     = tw_x[TWX_W-1:FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (ce) begin
            if (en)
                acc <= acc + tw;
            else
                acc <= '0;
        end
    end

    // Quadrant offset lands on the two most significant phase bits only
    always_comb begin
        phase  = acc[ACC_W-1 -: PHASE_TOP] + {quad, {LUT_AW{1'b0}}};
        addr_o = lut_addr_t'(phase);
    end

endmodule

// File: rtl/quad_carrier_cos_lut.sv
module quad_carrier_cos_lut
    import quad_carrier_synth_pkg::*;
#(
    parameter int CAR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  logic                    en,
    input  lut_addr_t               addr,
    output logic signed [CAR_W-1:0] val_o
);

    localparam int  DEPTH = 2 ** LUT_AW;
    localparam int  MAG_W = CAR_W - 1;
    localparam real AMP   = real'((2 ** (CAR_W - 1)) - 1);
    localparam real PI    = 3.141592653589793;

    logic [MAG_W-1:0] rom [DEPTH];

    // Quarter-wave sine sampled at bin centres
    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        localparam real ANG = (real'(g) + 0.5) * PI / real'(4 * DEPTH) * 2.0;
        localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
        assign rom[g] = MAG_W'(VAL);
    end

    logic [LUT_AW-1:0]       idx;
    logic                    neg;
    logic [MAG_W-1:0]        mag;
    logic signed [CAR_W-1:0] cosv;

    // cos rebuilt from sin: mirror in quadrants 0 and 2, negate in 1 and 2
    always_comb begin
        idx  = addr.quadrant[0] ? addr.index : ~addr.index;
        neg  = addr.quadrant[1] ^ addr.quadrant[0];
        mag  = rom[idx];
        cosv = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

    always_ff @(posedge clk) begin
        if (rst)
            val_o <= '0;
        else if (ce)
            val_o <= en ? cosv : '0;
    end

endmodule

// File: rtl/quad_carrier_sum.sv
module quad_carrier_sum #(
    parameter int NUM_CAR = 4,
    parameter int CAR_W   = 12,
    parameter int OUT_W   = 14
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  logic signed [CAR_W-1:0] car_i [NUM_CAR],
    output logic signed [OUT_W-1:0] sum_o
);

    logic signed [OUT_W-1:0] total;

    always_comb begin
        total = '0;
        for (int i = 0; i < NUM_CAR; i++)
            total = total + OUT_W'(car_i[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            sum_o <= '0;
        else if (ce)
            sum_o <= total;
    end

endmodule

// File: rtl/quad_carrier_synth.sv
module quad_carrier_synth
    import quad_carrier_synth_pkg::*;
#(
    parameter int              NUM_CAR = 4,
    parameter int              ACC_W   = 32,
    parameter int              FRAC_W  = 16,
    parameter int              CAR_W   = 12,
    parameter longint unsigned FS_HZ   = 64'd125_000_000,
    parameter int              OUT_W   = CAR_W + $clog2(NUM_CAR)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ce,
    input  logic [NUM_CAR-1:0]          car_en,
    input  logic [NUM_CAR*CODE_W-1:0]   car_code,
    input  logic [1:0]                  quad,
    output logic signed [OUT_W-1:0]     sample_o
);

    lut_addr_t               addr [NUM_CAR];
    logic signed [CAR_W-1:0] car_val [NUM_CAR];
    quad_e                   quad_q;

    assign quad_q = quad_e'(quad);

    for (genvar g = 0; g < NUM_CAR; g++) begin : g_car
        quad_carrier_nco #(
            .ACC_W  (ACC_W),
            .FRAC_W (FRAC_W),
            .FS_HZ  (FS_HZ)
        ) u_nco (
            .clk    (clk),
            .rst    (rst),
            .ce     (ce),
            .en     (car_en[g]),
            .code   (car_code[g*CODE_W +: CODE_W]),
            .quad   (quad_q),
            .addr_o (addr[g])
        );

        quad_carrier_cos_lut #(
            .CAR_W (CAR_W)
        ) u_lut (
            .clk   (clk),
            .rst   (rst),
            .ce    (ce),
            .en    (car_en[g]),
            .addr  (addr[g]),
            .val_o (car_val[g])
        );
    end

    quad_carrier_sum #(
        .NUM_CAR (NUM_CAR),
        .CAR_W   (CAR_W),
        .OUT_W   (OUT_W)
    ) u_sum (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .car_i (car_val),
        .sum_o (sample_o)
    );

endmodule

// File: rtl/quad_carrier_synth_chk.sv
module quad_carrier_synth_chk #(
    parameter int NUM_CAR = 4,
    parameter int CAR_W   = 12,
    parameter int OUT_W   = 14
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ce,
    input logic [NUM_CAR-1:0]      car_en,
    input logic signed [OUT_W-1:0] sample_o
);

    localparam int LIMIT = NUM_CAR * ((2 ** (CAR_W - 1)) - 1);

    logic [1:0] off_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            off_cnt <= '0;
        else if (ce)
            off_cnt <= (car_en == '0) ? ((off_cnt == 2'd2) ? 2'd2 : off_cnt + 2'd1) : 2'd0;
    end

    // R1: reset clears the output
    a_r1_reset_zero: assert property (@(posedge clk) rst |=> (sample_o == '0))
        else $error("a_r1_reset_zero");

    // R8: no tick, no change
    a_r8_hold: assert property (@(posedge clk) disable iff (rst) !ce |=> $stable(sample_o))
        else $error("a_r8_hold");

    // R7: guard bits keep the sum inside the full-scale range
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ($signed(sample_o) <= LIMIT) && ($signed(sample_o) >= -LIMIT))
        else $error("a_r7_no_overflow");

    // R6: two ticks with every carrier off give silence
    always_ff @(posedge clk) begin
        if (!rst && off_cnt == 2'd2)
            a_r6_silent: assert (sample_o == '0) else $error("a_r6_silent");
    end

endmodule

bind quad_carrier_synth quad_carrier_synth_chk #(
    .NUM_CAR (NUM_CAR),
    .CAR_W   (CAR_W),
    .OUT_W   (OUT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .car_en   (car_en),
    .sample_o (sample_o)
);

// File: tb/tb_quad_carrier_synth.sv
module tb_quad_carrier_synth;

    localparam int  CLK_PERIOD = 10;
    localparam int  NCAR       = 4;
    localparam int  AMP        = 2047;
    localparam real FS         = 125.0e6;
    localparam real PI         = 3.141592653589793;

    logic              clk = 1'b0;
    logic              rst_d = 1'b1;
    logic              ce_d = 1'b1;
    logic [NCAR-1:0]   en_d = '0;
    logic [7:0]        code_d [NCAR];
    logic [1:0]        quad_d = 2'd0;
    logic signed [13:0] sample_o;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model state
    logic [31:0] m_acc [NCAR];
    int exp1 = 0, exp2 = 0, tol1 = 0, tol2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_carrier_synth dut (
        .clk      (clk),
        .rst      (rst_d),
        .ce       (ce_d),
        .car_en   (en_d),
        .car_code ({code_d[3], code_d[2], code_d[1], code_d[0]}),
        .quad     (quad_d),
        .sample_o (sample_o)
    );

    function automatic logic [31:0] ideal_tw(input int code);
        int  c;
        real w;
        c = (code > 250) ? 250 : code;
        w = (5.0e6 + real'(c) * 1.0e5) * 4294967296.0 / FS;
        return 32'($rtoi($floor(w + 0.5)));
    endfunction

    function automatic int car_val(input logic [31:0] acc, input logic [1:0] q);
        logic [31:0] p;
        real ang, r;
        p   = acc + {q, 30'd0};
        ang = 2.0 * PI * (real'(p[31:22]) + 0.5) / 1024.0;
        r   = real'(AMP) * $cos(ang);
        if (r >= 0.0) return $rtoi($floor(r + 0.5));
        return -$rtoi($floor(-r + 0.5));
    endfunction

    task automatic check_near(input int act, input int exp, input int tol, input string req);
        int d;
        n_checks++;
        d = (act > exp) ? act - exp : exp - act;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d tol=%0d", req, act, exp, tol);
        end
    endtask

    task automatic tick(input bit chk, input string req);
        @(posedge clk);
        if (rst_d) begin
            for (int i = 0; i < NCAR; i++) m_acc[i] = '0;
            exp1 = 0; exp2 = 0; tol1 = 0; tol2 = 0;
        end else if (ce_d) begin
            exp2 = exp1; tol2 = tol1; exp1 = 0; tol1 = 0;
            for (int i = 0; i < NCAR; i++) begin
                if (en_d[i]) begin
                    exp1 += car_val(m_acc[i], quad_d);
                    tol1++;
                    m_acc[i] = m_acc[i] + ideal_tw(int'(code_d[i]));
                end else begin
                    m_acc[i] = '0;
                end
            end
        end
        @(negedge clk);
        if (chk) check_near(int'(sample_o), exp2, tol2, req);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) tick(1'b1, req);
    endtask

    task automatic silence();
        en_d = '0;
        tick(1'b0, "R6");
        tick(1'b0, "R6");
    endtask

    task automatic t_reset();
        rst_d = 1'b1;
        tick(1'b0, "R1"); tick(1'b0, "R1");
        check_near(int'(sample_o), 0, 0, "R1");
        rst_d = 1'b0;
    endtask

    task automatic t_latency();
        code_d[0] = 8'd0; en_d = 4'b0001; quad_d = 2'd0;
        tick(1'b0, "R9");
        check_near(int'(sample_o), 0, 0, "R9");
        tick(1'b0, "R9");
        check_near(int'(sample_o), AMP, 0, "R9");
        run(200, "R4");
    endtask

    task automatic t_freq_sweep();
        int codes [3] = '{0, 125, 250};
        for (int j = 0; j < 3; j++) begin
            silence();
            code_d[1] = 8'(codes[j]);
            en_d = 4'b0010;
            run(1500, "R2");
        end
    endtask

    task automatic t_clamp();
        silence();
        code_d[0] = 8'd250; code_d[2] = 8'd255;
        en_d = 4'b0101;
        run(1500, "R3");
        // both carriers coherent, so the sum stays at twice one carrier
        silence();
        en_d = 4'b0100; code_d[2] = 8'd200;
        run(300, "R3");
    endtask

    task automatic t_quad();
        silence();
        code_d[3] = 8'd33; en_d = 4'b1000;
        for (int i = 0; i < 40; i++) begin
            quad_d = 2'(i);
            run(7, "R5");
        end
    endtask

    task automatic t_multi();
        silence();
        code_d[0] = 8'd10; code_d[1] = 8'd77; code_d[2] = 8'd160; code_d[3] = 8'd240;
        en_d = 4'b1111;
        for (int i = 0; i < 50; i++) begin
            quad_d = 2'(i * 3);
            run(20, "R4");
        end
    endtask

    task automatic t_full_scale();
        silence();
        for (int i = 0; i < NCAR; i++) code_d[i] = 8'd40;
        quad_d = 2'd0; en_d = 4'b1111;
        tick(1'b0, "R7"); tick(1'b0, "R7");
        check_near(int'(sample_o), 4 * AMP, 0, "R7");
        silence();
        quad_d = 2'd2; en_d = 4'b1111;
        tick(1'b0, "R7"); tick(1'b0, "R7");
        check_near(int'(sample_o), -4 * AMP, 0, "R7");
        run(100, "R7");
    endtask

    task automatic t_disable();
        silence();
        code_d[0] = 8'd5; code_d[1] = 8'd90; code_d[2] = 8'd180; code_d[3] = 8'd230;
        en_d = 4'b1111;
        run(100, "R6");
        en_d = 4'b1101;
        run(100, "R6");
        en_d = 4'b1111;
        run(100, "R6");
        en_d = '0;
        tick(1'b0, "R6"); tick(1'b0, "R6");
        check_near(int'(sample_o), 0, 0, "R6");
        tick(1'b1, "R6");
    endtask

    task automatic t_ce();
        int held;
        silence();
        code_d[0] = 8'd60; code_d[1] = 8'd140; en_d = 4'b0011;
        run(50, "R8");
        held = int'(sample_o);
        ce_d = 1'b0;
        for (int i = 0; i < 6; i++) begin
            quad_d = 2'(i);
            tick(1'b0, "R8");
            check_near(int'(sample_o), held, 0, "R8");
        end
        for (int i = 0; i < 200; i++) begin
            ce_d = (i % 3) != 1;
            tick(1'b1, "R8");
        end
        ce_d = 1'b1;
    endtask

    task automatic t_reset_mid();
        code_d[0] = 8'd120; en_d = 4'b0001;
        run(30, "R1");
        t_reset();
        en_d = '0;
        tick(1'b0, "R1");
        check_near(int'(sample_o), 0, 0, "R1");
    endtask

    initial begin
        for (int i = 0; i < NCAR; i++) begin
            code_d[i] = '0;
            m_acc[i]  = '0;
        end
        @(negedge clk);
        t_reset();
        t_latency();
        t_freq_sweep();
        t_clamp();
        t_quad();
        t_multi();
        t_full_scale();
        t_disable();
        t_ce();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule